// File: doc/BRIEF.md
# Carrier Detect Qualifier with Hysteresis

This block decides whether a usable carrier is being received. Its input is a stream of received-level estimates, for example squared magnitudes, each marked valid by a sample enable. The block compares each valid estimate against a programmable threshold. A change of state is accepted only after the comparison has held for a programmable number of consecutive valid samples. There are two counts: a longer one that qualifies a new carrier and a shorter one that releases a lost carrier. The output is active low: it reads low while a carrier is present.

Hysteresis comes from the threshold, which depends on the current output state. With no carrier, a level must be strictly above the programmed threshold to count toward detection. With a carrier held, the threshold falls to half the programmed value, which is 3 dB in power, so the carrier is kept as long as the level stays strictly above that half. The full threshold applies again as soon as the carrier is released. Typical use is a long assert count, about twelve times the release count, so that short bursts are rejected while a lost carrier is reported quickly.

Top module: `cd_qualifier`

## Requirements
- R1: While reset is asserted, and after it is released, `carrier_n` is 1 (no carrier) and the full threshold `on_thresh` is the active comparison.
- R2: With `carrier_n` = 1, `carrier_n` goes to 0 on the clock edge of the `assert_cnt`-th consecutive valid sample whose `level` is strictly greater than `on_thresh`.
- R3: During qualification, a valid sample with `level` <= `on_thresh` (equality included) restarts the count and leaves `carrier_n` at 1.
- R4: With `carrier_n` = 0, the comparison threshold is `on_thresh >> 1`. A valid sample with `level` strictly greater than that value keeps `carrier_n` at 0.
- R5: With `carrier_n` = 0, `carrier_n` returns to 1 on the edge of the `release_cnt`-th consecutive valid sample with `level` <= `on_thresh >> 1`. After that the full threshold applies again.
- R6: During release, a valid sample with `level` > `on_thresh >> 1` restarts the release count and keeps `carrier_n` at 0.
- R7: On a cycle with `sample_en` = 0, `level` is ignored: neither `carrier_n` nor the qualification progress changes.
- R8: A delay count of 0 behaves like 1: the first qualifying sample changes the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_en | input | 1 | Marks `level` as a valid new estimate |
| level | input | LW | Received level estimate (power-like, unsigned) |
| on_thresh | input | LW | Detection threshold; half of it is used while carrier is held |
| assert_cnt | input | CW | Consecutive samples needed to declare carrier |
| release_cnt | input | CW | Consecutive samples needed to drop carrier |
| carrier_n | output | 1 | Carrier detect, 0 = carrier present |

## Verification
The assertions check, on every cycle, three things:
- the output moves only after a valid sample;
- detection never follows a sample at or below the full threshold;
- release never follows a sample above the halved threshold.

Only the bench scenarios can show the exact counts, that is, that the output changes on the Nth consecutive sample and not on the one before. They also cover the restart of a count after an interrupting sample, the equality cases at both thresholds, the handling of a delay count of zero, and that idle cycles leave the qualification progress untouched.

// File: rtl/cd_qualifier.sv
module cd_qualifier #(
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_en,
  input  logic [LW-1:0] level,
  input  logic [LW-1:0] on_thresh,
  input  logic [CW-1:0] assert_cnt,
  input  logic [CW-1:0] release_cnt,
  output logic          carrier_n
);

  logic          held;
  logic [CW-1:0] run;
  logic [LW-1:0] active_thr;
  logic          above;
  logic          differ;
  logic [CW-1:0] limit;
  logic [CW:0]   next_run;
  logic          done;

  assign active_thr = held ? (on_thresh >> 1) : on_thresh;
  assign above      = level > active_thr;
  assign differ     = above != held;
  assign limit      = held ? release_cnt : assert_cnt;
  assign next_run   = {1'b0, run} + 1'b1;
  assign done       = next_run >= {1'b0, limit};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      run  <= '0;
    end else if (sample_en) begin
      if (!differ) begin
        run <= '0;
      end else if (done) begin
        held <= ~held;
        run  <= '0;
      end else begin
        run <= next_run[CW-1:0];
      end
    end
  end

  assign carrier_n = ~held;

  // R1
  reset_high_chk: assert property (@(posedge clk) !rst_n |=> carrier_n);

  // R7
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(carrier_n));

  // R3
  no_early_detect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && carrier_n && !(level > on_thresh)) |=> carrier_n);

  // R6
  no_early_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !carrier_n && (level > (on_thresh >> 1))) |=> !carrier_n);

endmodule

// File: tb/test_cd_qualifier.sv
module test_cd_qualifier;
  localparam int LW = 16;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sample_en = 1'b0;
  logic [LW-1:0] level = '0;
  logic [LW-1:0] on_thresh = 16'd100;
  logic [CW-1:0] assert_cnt = 16'd4;
  logic [CW-1:0] release_cnt = 16'd2;
  logic          carrier_n;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cd_qualifier #(.LW(LW), .CW(CW)) i_cd_qualifier (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .level(level),
    .on_thresh(on_thresh), .assert_cnt(assert_cnt),
    .release_cnt(release_cnt), .carrier_n(carrier_n)
  );

  // {level, expected carrier_n after the sample}; thresholds 100 / 50, counts 4 / 2
  localparam int NV = 13;
  localparam logic [16:0] VEC [NV] = '{
    {16'd150, 1'b1},  // R2 count 1
    {16'd150, 1'b1},  // R2 count 2
    {16'd100, 1'b1},  // R3 equal restarts
    {16'd150, 1'b1},
    {16'd150, 1'b1},
    {16'd150, 1'b1},
    {16'd150, 1'b0},  // R2 fourth sample detects
    {16'd60,  1'b0},  // R4 above half threshold holds
    {16'd40,  1'b0},  // R5 release count 1
    {16'd60,  1'b0},  // R6 restart
    {16'd50,  1'b0},  // R5 equal counts as low
    {16'd30,  1'b1},  // R5 second sample releases
    {16'd80,  1'b1}   // R5 full threshold restored
  };

  task automatic check(input logic exp, input string req);
    checks++;
    if (carrier_n !== exp) begin
      errors++;
      $display("FAIL %s: carrier_n=%b expected %b", req, carrier_n, exp);
    end
  endtask

  task automatic sample(input logic en, input logic [LW-1:0] lv);
    sample_en = en;
    level = lv;
    @(negedge clk);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: timeout reached, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(1'b1, "R1 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(1'b1, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      sample(1'b1, VEC[i][16:1]);
      check(VEC[i][0], $sformatf("R2-R6 vector %0d", i));
    end

    // R7: idle cycles do not advance qualification
    sample(1'b1, 16'd150);
    sample(1'b1, 16'd150);
    sample(1'b1, 16'd150);
    for (int i = 0; i < 10; i++) sample(1'b0, 16'd150);
    check(1'b1, "R7 idle with high level");
    sample(1'b1, 16'd150);
    check(1'b0, "R7 progress kept across idle");
    for (int i = 0; i < 5; i++) sample(1'b0, 16'd0);
    check(1'b0, "R7 idle with low level while held");

    // R8: zero counts act as one
    sample(1'b1, 16'd0);
    sample(1'b1, 16'd0);
    check(1'b1, "R5 released before R8");
    assert_cnt = '0;
    release_cnt = '0;
    sample(1'b1, 16'd101);
    check(1'b0, "R8 zero assert count");
    sample(1'b1, 16'd51);
    check(1'b0, "R4 held at half plus one");
    sample(1'b1, 16'd10);
    check(1'b1, "R8 zero release count");

    // R1: reset in the detected state
    sample(1'b1, 16'd200);
    check(1'b0, "R8 detect again");
    rst_n = 1'b0;
    sample(1'b0, 16'd200);
    check(1'b1, "R1 reset clears carrier");
    rst_n = 1'b1;
    assert_cnt = 16'd2;
    sample(1'b1, 16'd90);
    check(1'b1, "R1 full threshold after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule